// File: doc/BRIEF.md
# DMA Interface Register Bank

This block is the software-visible register set of a 16-bit DMA interface that sits on a multiplexed address/data bus. It occupies four word slots above a base address that board strapping selects. The slots hold a transfer counter, a transfer address, a control/status word and a data buffer pair. A processor-side slave port reads and writes the slots. A cycle sequencer outside the block moves the data on the bus and pulses strobes into the bank: a transfer completed, a non-existent memory was hit, a cycle started, a memory word arrived for the device.

Software loads the counter with the negative (two's complement) of the number of words, loads the start address, then writes the start bit. The counter counts up once per transfer. When it reaches zero, or when an error is flagged, the ready flag returns and an interrupt flag is raised if enabled. The address counter steps by one word per transfer. Its carry-out advances a two-bit extended address field kept in the control word.

The slave port has no back-pressure: an access with `acc_valid` high is taken in the cycle it is presented. Read data returns with `rd_valid` one cycle later, and only for an address inside the block's window. Device and sequencer strobes are single-cycle pulses. Levels (`dev_attn`, `dev_status`, `dev_a00`) are sampled live.

Top module: `dma_regbank`

## Requirements
- R1: `acc_addr` is a word address (byte address bits 15:1). An access hits when its bits 15:3 equal `base_sw`, and bits 2:1 pick the slot: 0 counter, 1 address, 2 control word, 3 data buffers. A read hit gives `rd_valid`=1 with the slot's value one cycle after the access. A miss gives no `rd_valid` and changes nothing.
- R2: The counter reads back as written. A `seq_step` pulse with `seq_wc_inc_en`=1 adds one. A step that brings it from 0xFFFF to 0x0000 sets READY. With `seq_wc_inc_en`=0 the step leaves it unchanged.
- R3: The address slot stores bits 15:1, and its bit 0 reads the live `dev_a00`. A step with `seq_ba_inc_en`=1 adds two. Carry-out past 0xFFFE wraps it to zero and adds one to the extended field (control bits 5:4). `dma_addr` = {extended field, address bits 15:1, `dev_a00`}.
- R4: Writing 1 to control bit 0 through the low byte lane (start) clears READY. Bit 0 always reads 0.
- R5: READY (control bit 7, `ready` port) is 1 after reset. A counter overflow or ERROR sets it, and the set takes priority over a start written in the same cycle.
- R6: Control bit 15 (ERROR) reads bit 14 OR bit 13. Bit 13 reads the live `dev_attn`. Bit 14 (non-existent memory) is set by `seq_nex`, is cleared by writing 0 to it through the high lane, and ignores a written 1.
- R7: Control bits 3:1 (function outputs, driven on `func_out`), 6 (interrupt enable) and 5:4 (extended field) are written through the low lane and cleared by reset. Bits 11:9 read `dev_status[2:0]` live.
- R8: Control bit 8 (cycle) is set by `dev_cyc_req`, cleared by `seq_cyc_start`, and written through the high lane. The request wins over both.
- R9: Slot 3 reads the input buffer, which captures `dev_in_data` on `dev_cyc_req`. Writes to slot 3 load the output buffer (`out_data`) per byte lane. `seq_rd_load` loads the whole output buffer and wins over a same-cycle write.
- R10: Writes to read-only control bits (15:9 apart from 14 and 8, and bit 7) have no effect. Counter and address writes with other than both byte enables are ignored.
- R11: `irq_req` rises when READY rises while the interrupt enable is 1. A start write, or a low-lane write with bit 6 = 0, clears it.
- R12: A software write to the counter, the address or the extended field wins over a same-cycle increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sw | input | 13 | Strapped base address bits 15:3 |
| acc_valid | input | 1 | Slave access present |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | 15 | Word address (byte address bits 15:1) |
| acc_be | input | 2 | Byte lane enables for writes |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 16 | Read response data |
| dev_in_data | input | 16 | Device input word |
| dev_cyc_req | input | 1 | Device cycle request pulse |
| dev_a00 | input | 1 | Device byte-select address bit |
| dev_attn | input | 1 | Device attention level |
| dev_status | input | 3 | Device status levels |
| seq_step | input | 1 | Transfer-completed pulse |
| seq_wc_inc_en | input | 1 | Counter advance enable for the step |
| seq_ba_inc_en | input | 1 | Address advance enable for the step |
| seq_nex | input | 1 | Non-existent memory pulse |
| seq_cyc_start | input | 1 | DMA cycle started pulse |
| seq_rd_load | input | 1 | Memory word for device valid |
| seq_rd_data | input | 16 | Memory word for device |
| out_data | output | 16 | Output buffer to device |
| func_out | output | 3 | Function bits to device |
| ready | output | 1 | READY flag |
| irq_req | output | 1 | Interrupt request flag |
| dma_addr | output | 18 | Full transfer byte address |

## Verification
The embedded properties watch, every cycle, the counter wrap at all-ones, the address carry into the extended field, and the rule that a software write beats an increment. They also check that ERROR forces READY the next cycle, that the non-existent-memory flag never sets without its strobe, that the interrupt flag rises only with READY under enable, and that read responses appear only after reads. The bench scenarios are needed for the read-back layout of the control word, for ignored writes to read-only bits and to partial-width counter writes, and for the base-address decode. They also cover the byte-lane merge into the output buffer and a full start-to-overflow sequence with its interrupt.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int DW    = 16;
  localparam int EXT_W = 2;

  typedef enum logic [1:0] {
    SLOT_WC   = 2'd0,
    SLOT_BA   = 2'd1,
    SLOT_CSR  = 2'd2,
    SLOT_DBUF = 2'd3
  } slot_e;

  localparam int B_GO    = 0;
  localparam int B_FUNC  = 1;
  localparam int B_EXT   = 4;
  localparam int B_IE    = 6;
  localparam int B_CYC   = 8;
  localparam int B_NEX   = 14;
endpackage

// File: rtl/dma_regbank_decode.sv
module dma_regbank_decode
  import dma_regbank_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:1] acc_addr,
  input  logic [AW-1:3] base_sw,
  output logic [3:0]    wr_sel,
  output logic          rd_hit,
  output slot_e         slot
);
  logic hit;

  assign hit    = acc_valid && (acc_addr[AW-1:3] == base_sw);
  assign slot   = slot_e'(acc_addr[2:1]);
  assign rd_hit = hit && !acc_write;

  for (genvar s = 0; s < 4; s++) begin : g_sel
    assign wr_sel[s] = hit && acc_write && (acc_addr[2:1] == 2'(s));
  end
endmodule

// File: rtl/dma_regbank_counters.sv
module dma_regbank_counters
  import dma_regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wc_wr,
  input  logic             ba_wr,
  input  logic             ext_wr,
  input  logic [DW-1:0]    wc_wdata,
  input  logic [DW-1:1]    ba_wdata,
  input  logic [EXT_W-1:0] ext_wdata,
  input  logic             step,
  input  logic             wc_en,
  input  logic             ba_en,
  output logic [DW-1:0]    wc_q,
  output logic [DW-1:1]    ba_q,
  output logic [EXT_W-1:0] ext_q,
  output logic             wc_ovf
);
  logic [DW-1:1] ba_sum;
  logic          ba_carry;

  assign {ba_carry, ba_sum} = {1'b0, ba_q} + 1'b1;
  assign wc_ovf = step && wc_en && !wc_wr && (wc_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n)                wc_q <= '0;
    else if (wc_wr)            wc_q <= wc_wdata;
    else if (step && wc_en)    wc_q <= wc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ba_q <= '0;
    else if (ba_wr)            ba_q <= ba_wdata;
    else if (step && ba_en)    ba_q <= ba_sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              ext_q <= '0;
    else if (ext_wr)                         ext_q <= ext_wdata;
    else if (step && ba_en && ba_carry && !ba_wr) ext_q <= ext_q + 1'b1;
  end

  a_r2_wc_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wc_en && !wc_wr && wc_q == '1) |=> (wc_q == '0));

  a_r3_ext_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ba_en && !ba_wr && !ext_wr && ba_q == '1)
      |=> (ba_q == '0 && ext_q == EXT_W'($past(ext_q) + 1'b1)));

  a_r12_write_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
    wc_wr |=> (wc_q == $past(wc_wdata)));
endmodule

// File: rtl/dma_regbank_csr.sv
module dma_regbank_csr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_wr,
  input  logic       hi_wr,
  input  logic       w_go,
  input  logic [2:0] w_func,
  input  logic       w_ie,
  input  logic       w_cyc,
  input  logic       w_nex,
  input  logic       wc_ovf,
  input  logic       seq_nex,
  input  logic       dev_attn,
  input  logic       dev_cyc_req,
  input  logic       seq_cyc_start,
  output logic       ready_q,
  output logic       nex_q,
  output logic       error_o,
  output logic       cycle_q,
  output logic       ie_q,
  output logic [2:0] func_q,
  output logic       irq_q
);
  logic go, ready_set;

  assign go        = lo_wr && w_go;
  assign error_o   = nex_q || dev_attn;
  assign ready_set = wc_ovf || error_o || seq_nex;

  always_ff @(posedge clk) begin
    if (!rst_n)          ready_q <= 1'b1;
    else if (ready_set)  ready_q <= 1'b1;
    else if (go)         ready_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                irq_q <= 1'b0;
    else if (!ready_q && ready_set && ie_q) irq_q <= 1'b1;
    else if (go || (lo_wr && !w_ie))        irq_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               nex_q <= 1'b0;
    else if (seq_nex)         nex_q <= 1'b1;
    else if (hi_wr && !w_nex) nex_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             cycle_q <= 1'b0;
    else if (dev_cyc_req)   cycle_q <= 1'b1;
    else if (hi_wr)         cycle_q <= w_cyc;
    else if (seq_cyc_start) cycle_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      func_q <= '0;
      ie_q   <= 1'b0;
    end else if (lo_wr) begin
      func_q <= w_func;
      ie_q   <= w_ie;
    end
  end

  a_r5_error_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> ready_q);

  a_r4_go_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !ready_set) |=> !ready_q);

  a_r6_nex_only_by_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!nex_q && !seq_nex) |=> !nex_q);

  a_r8_request_sets_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cyc_req |=> cycle_q);

  a_r11_irq_on_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($rose(ready_q) && $past(ie_q)));
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:3]       base_sw,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [AW-1:1]       acc_addr,
  input  logic [1:0]          acc_be,
  input  logic [DW-1:0]       acc_wdata,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  input  logic [DW-1:0]       dev_in_data,
  input  logic                dev_cyc_req,
  input  logic                dev_a00,
  input  logic                dev_attn,
  input  logic [2:0]          dev_status,
  input  logic                seq_step,
  input  logic                seq_wc_inc_en,
  input  logic                seq_ba_inc_en,
  input  logic                seq_nex,
  input  logic                seq_cyc_start,
  input  logic                seq_rd_load,
  input  logic [DW-1:0]       seq_rd_data,
  output logic [DW-1:0]       out_data,
  output logic [2:0]          func_out,
  output logic                ready,
  output logic                irq_req,
  output logic [EXT_W+DW-1:0] dma_addr
);
  localparam int LANES = DW / 8;

  logic [3:0]       wr_sel;
  logic             rd_hit;
  slot_e            slot;
  logic             wc_wr, ba_wr, csr_lo, csr_hi;
  logic [LANES-1:0] db_we;
  logic [DW-1:0]    wc_q, csr_word, in_buf_q, rd_mux;
  logic [DW-1:1]    ba_q;
  logic [EXT_W-1:0] ext_q;
  logic             wc_ovf, nex_q, error_o, cycle_q, ie_q;

  dma_regbank_decode #(.AW(AW)) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .base_sw   (base_sw),
    .wr_sel    (wr_sel),
    .rd_hit    (rd_hit),
    .slot      (slot)
  );

  assign wc_wr  = wr_sel[SLOT_WC]  && (&acc_be);
  assign ba_wr  = wr_sel[SLOT_BA]  && (&acc_be);
  assign csr_lo = wr_sel[SLOT_CSR] && acc_be[0];
  assign csr_hi = wr_sel[SLOT_CSR] && acc_be[1];

  dma_regbank_counters u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wc_wr     (wc_wr),
    .ba_wr     (ba_wr),
    .ext_wr    (csr_lo),
    .wc_wdata  (acc_wdata),
    .ba_wdata  (acc_wdata[DW-1:1]),
    .ext_wdata (acc_wdata[B_EXT +: EXT_W]),
    .step      (seq_step),
    .wc_en     (seq_wc_inc_en),
    .ba_en     (seq_ba_inc_en),
    .wc_q      (wc_q),
    .ba_q      (ba_q),
    .ext_q     (ext_q),
    .wc_ovf    (wc_ovf)
  );

  dma_regbank_csr u_csr (
    .clk           (clk),
    .rst_n         (rst_n),
    .lo_wr         (csr_lo),
    .hi_wr         (csr_hi),
    .w_go          (acc_wdata[B_GO]),
    .w_func        (acc_wdata[B_FUNC +: 3]),
    .w_ie          (acc_wdata[B_IE]),
    .w_cyc         (acc_wdata[B_CYC]),
    .w_nex         (acc_wdata[B_NEX]),
    .wc_ovf        (wc_ovf),
    .seq_nex       (seq_nex),
    .dev_attn      (dev_attn),
    .dev_cyc_req   (dev_cyc_req),
    .seq_cyc_start (seq_cyc_start),
    .ready_q       (ready),
    .nex_q         (nex_q),
    .error_o       (error_o),
    .cycle_q       (cycle_q),
    .ie_q          (ie_q),
    .func_q        (func_out),
    .irq_q         (irq_req)
  );

  // Input buffer: captured when the device requests a cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)           in_buf_q <= '0;
    else if (dev_cyc_req) in_buf_q <= dev_in_data;
  end

  // Output buffer: one register per byte lane; sequencer load wins.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign db_we[l] = wr_sel[SLOT_DBUF] && acc_be[l];
    always_ff @(posedge clk) begin
      if (!rst_n)           out_data[l*8 +: 8] <= '0;
      else if (seq_rd_load) out_data[l*8 +: 8] <= seq_rd_data[l*8 +: 8];
      else if (db_we[l])    out_data[l*8 +: 8] <= acc_wdata[l*8 +: 8];
    end
  end

  assign csr_word = {error_o, nex_q, dev_attn, 1'b0, dev_status, cycle_q,
                     ready, ie_q, ext_q, func_out, 1'b0};

  always_comb begin
    unique case (slot)
      SLOT_WC:  rd_mux = wc_q;
      SLOT_BA:  rd_mux = {ba_q, dev_a00};
      SLOT_CSR: rd_mux = csr_word;
      default:  rd_mux = in_buf_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_hit;
      if (rd_hit) rd_data <= rd_mux;
    end
  end

  assign dma_addr = {ext_q, ba_q, dev_a00};

  a_r1_rd_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && !acc_write));

  a_r9_seq_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rd_load |=> (out_data == $past(seq_rd_data)));
endmodule

// File: tb/dma_regbank_tb_top.sv
module dma_regbank_tb_top;
  localparam logic [15:0] BASE = 16'hF508;
  localparam logic [15:0] STAT = 16'h0A00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_write = 0;
  logic [15:1] acc_addr = '0;
  logic [1:0]  acc_be = 2'b11;
  logic [15:0] acc_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [15:0] dev_in_data = '0;
  logic        dev_cyc_req = 0, dev_a00 = 1, dev_attn = 0;
  logic [2:0]  dev_status = 3'b101;
  logic        seq_step = 0, seq_wc_inc_en = 0, seq_ba_inc_en = 0;
  logic        seq_nex = 0, seq_cyc_start = 0, seq_rd_load = 0;
  logic [15:0] seq_rd_data = '0;
  logic [15:0] out_data;
  logic [2:0]  func_out;
  logic        ready, irq_req;
  logic [17:0] dma_addr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .base_sw(BASE[15:3]),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .dev_in_data(dev_in_data), .dev_cyc_req(dev_cyc_req), .dev_a00(dev_a00),
    .dev_attn(dev_attn), .dev_status(dev_status), .seq_step(seq_step),
    .seq_wc_inc_en(seq_wc_inc_en), .seq_ba_inc_en(seq_ba_inc_en),
    .seq_nex(seq_nex), .seq_cyc_start(seq_cyc_start), .seq_rd_load(seq_rd_load),
    .seq_rd_data(seq_rd_data), .out_data(out_data), .func_out(func_out),
    .ready(ready), .irq_req(irq_req), .dma_addr(dma_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:1] wa(input logic [15:0] byte_addr);
    return byte_addr[15:1];
  endfunction

  task automatic wr(input logic [15:0] baddr, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = wa(baddr); acc_wdata = d; acc_be = be;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_be = 2'b11;
  endtask

  task automatic rd(input logic [15:0] baddr, output logic [15:0] d, output logic v);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = wa(baddr);
    @(negedge clk);
    acc_valid = 0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] off, input logic [15:0] exp);
    logic [15:0] d; logic v;
    rd(BASE + off, d, v);
    chk({tag, " rd_valid"}, 32'(v), 32'd1);
    chk(tag, 32'(d), 32'(exp));
  endtask

  task automatic step(input logic wce, input logic bae);
    @(negedge clk);
    seq_step = 1; seq_wc_inc_en = wce; seq_ba_inc_en = bae;
    @(negedge clk);
    seq_step = 0; seq_wc_inc_en = 0; seq_ba_inc_en = 0;
  endtask

  task automatic t_reset();
    chk("R5 ready after reset", 32'(ready), 32'd1);
    chk("R11 irq after reset", 32'(irq_req), 32'd0);
    rd_chk("R5 csr reset", 16'd4, STAT | 16'h0080);
    rd_chk("R2 wc reset", 16'd0, 16'h0000);
    rd_chk("R3 ba reset", 16'd2, 16'h0001);
  endtask

  task automatic t_count();
    wr(BASE, 16'hFFFE, 2'b11);
    rd_chk("R2 wc readback", 16'd0, 16'hFFFE);
    wr(BASE + 4, 16'h0001, 2'b11);
    chk("R4 go clears ready", 32'(ready), 32'd0);
    rd_chk("R4 go reads zero", 16'd4, STAT);
    step(1, 0);
    rd_chk("R2 wc step", 16'd0, 16'hFFFF);
    chk("R2 no early ready", 32'(ready), 32'd0);
    step(0, 1);
    rd_chk("R2 wc hold when disabled", 16'd0, 16'hFFFF);
    step(1, 0);
    rd_chk("R2 wc reaches zero", 16'd0, 16'h0000);
    chk("R2 overflow sets ready", 32'(ready), 32'd1);
    wr(BASE, 16'h1234, 2'b01);
    rd_chk("R10 wc byte write ignored", 16'd0, 16'h0000);
  endtask

  task automatic t_addr();
    wr(BASE + 2, 16'hFFFE, 2'b11);
    rd_chk("R3 ba with a00=1", 16'd2, 16'hFFFF);
    dev_a00 = 0;
    rd_chk("R3 ba with a00=0", 16'd2, 16'hFFFE);
    wr(BASE + 2, 16'h1234, 2'b10);
    rd_chk("R10 ba byte write ignored", 16'd2, 16'hFFFE);
    wr(BASE + 4, 16'h0010, 2'b01);
    step(0, 1);
    rd_chk("R3 ba wraps", 16'd2, 16'h0000);
    rd_chk("R3 ext carry", 16'd4, STAT | 16'h00A0);
    chk("R3 dma_addr after carry", 32'(dma_addr), 32'h20000);
    step(0, 1);
    chk("R3 dma_addr step by two", 32'(dma_addr), 32'h20002);
    dev_a00 = 1;
  endtask

  task automatic t_error();
    @(negedge clk); seq_nex = 1; @(negedge clk); seq_nex = 0;
    rd_chk("R6 nex and error set", 16'd4, STAT | 16'hC0A0);
    wr(BASE + 4, 16'h4000, 2'b10);
    rd_chk("R6 nex write one ignored", 16'd4, STAT | 16'hC0A0);
    wr(BASE + 4, 16'h0000, 2'b10);
    rd_chk("R6 nex written to zero", 16'd4, STAT | 16'h00A0);
    dev_attn = 1;
    rd_chk("R6 attn and error", 16'd4, STAT | 16'hA0A0);
    wr(BASE + 4, 16'h0021, 2'b01);
    chk("R5 error beats go", 32'(ready), 32'd1);
    dev_attn = 0;
    wr(BASE + 4, 16'h0021, 2'b01);
    chk("R4 go without error", 32'(ready), 32'd0);
    wr(BASE, 16'hFFFF, 2'b11);
    step(1, 0);
    chk("R5 ready back after overflow", 32'(ready), 32'd1);
  endtask

  task automatic t_fields();
    wr(BASE + 4, 16'hFFFE, 2'b11);
    rd_chk("R7 R10 rw fields, ro ignored", 16'd4, STAT | 16'h01FE);
    chk("R7 func_out", 32'(func_out), 32'd7);
    wr(BASE + 4, 16'h0000, 2'b11);
    rd_chk("R7 fields cleared", 16'd4, STAT | 16'h0080);
    chk("R7 func_out cleared", 32'(func_out), 32'd0);
    dev_status = 3'b010;
    rd_chk("R7 status live", 16'd4, 16'h0480);
    dev_status = 3'b101;
  endtask

  task automatic t_cycle();
    dev_in_data = 16'h5A3C;
    @(negedge clk); dev_cyc_req = 1; @(negedge clk); dev_cyc_req = 0;
    dev_in_data = 16'h1111;
    rd_chk("R8 request sets cycle", 16'd4, STAT | 16'h0180);
    rd_chk("R9 input buffer latched", 16'd6, 16'h5A3C);
    @(negedge clk); seq_cyc_start = 1; @(negedge clk); seq_cyc_start = 0;
    rd_chk("R8 cycle start clears", 16'd4, STAT | 16'h0080);
    wr(BASE + 4, 16'h0100, 2'b10);
    rd_chk("R8 cycle written one", 16'd4, STAT | 16'h0180);
    wr(BASE + 4, 16'h0000, 2'b10);
    rd_chk("R8 cycle written zero", 16'd4, STAT | 16'h0080);
  endtask

  task automatic t_dbuf();
    wr(BASE + 6, 16'hBEEF, 2'b11);
    chk("R9 out word write", 32'(out_data), 32'hBEEF);
    wr(BASE + 6, 16'h0012, 2'b01);
    chk("R9 out low lane", 32'(out_data), 32'hBE12);
    wr(BASE + 6, 16'h3400, 2'b10);
    chk("R9 out high lane", 32'(out_data), 32'h3412);
    @(negedge clk); seq_rd_load = 1; seq_rd_data = 16'hC0DE;
    acc_valid = 1; acc_write = 1; acc_addr = wa(BASE + 6); acc_wdata = 16'h9999; acc_be = 2'b11;
    @(negedge clk); seq_rd_load = 0; acc_valid = 0; acc_write = 0;
    chk("R9 sequencer load wins", 32'(out_data), 32'hC0DE);
    rd_chk("R9 read gives input buffer", 16'd6, 16'h5A3C);
  endtask

  task automatic t_irq();
    wr(BASE, 16'hFFFF, 2'b11);
    wr(BASE + 4, 16'h0041, 2'b11);
    chk("R11 no irq at go", 32'(irq_req), 32'd0);
    step(1, 0);
    chk("R11 ready rises", 32'(ready), 32'd1);
    chk("R11 irq raised", 32'(irq_req), 32'd1);
    wr(BASE + 4, 16'h0041, 2'b11);
    chk("R11 go clears irq", 32'(irq_req), 32'd0);
    wr(BASE + 4, 16'h0000, 2'b01);
    wr(BASE, 16'hFFFF, 2'b11);
    step(1, 0);
    chk("R11 ready rises without enable", 32'(ready), 32'd1);
    chk("R11 no irq without enable", 32'(irq_req), 32'd0);
  endtask

  task automatic t_race();
    wr(BASE, 16'h0005, 2'b11);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = wa(BASE); acc_wdata = 16'h0010; acc_be = 2'b11;
    seq_step = 1; seq_wc_inc_en = 1;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; seq_step = 0; seq_wc_inc_en = 0;
    rd_chk("R12 write beats increment", 16'd0, 16'h0010);
  endtask

  task automatic t_decode();
    logic [15:0] d; logic v;
    wr(BASE ^ 16'h0100, 16'h7777, 2'b11);
    rd_chk("R1 miss write ignored", 16'd0, 16'h0010);
    rd(BASE ^ 16'h0100, d, v);
    chk("R1 miss read no valid", 32'(v), 32'd0);
    rd_chk("R1 slot 1 decode", 16'd2, 16'h0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_addr();
    t_error();
    t_fields();
    t_cycle();
    t_dbuf();
    t_irq();
    t_race();
    t_decode();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule